// File: doc/BRIEF.md
# Packet UART Frame Transmitter

This block serializes counted multi-byte packets onto an asynchronous serial line. Software first loads the payload bytes into a data queue. It then pushes the byte count of each packet into a length queue. For each queued length, the transmitter sends that many characters back to back, with no idle time between them. After the last character of a packet it holds the line idle for a programmable gap, and only then takes up the next length.

The block also controls an external half-duplex line driver. The driver can be held on permanently. It can also be switched on automatically for each packet, with a programmable lead time in clock cycles before the first start bit, and released once the final stop bit has finished.

A single mode word configures parity, the stop-bit count, the gap and the driver. A status word reports the configuration along with busy, error and queue state. Writing one reserved value to the mode word aborts all activity and empties both queues.

Top module: `pkt_uart_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `drv_en_o` is 0 and `status_o` is all zeros.
- R2: Each character is a low start bit, then 8 data bits least significant first, then a high stop bit. Every bit lasts `div_i` clock cycles, and the line is high whenever nothing is being sent.
- R3: Mode bit 6 enables a parity bit, sent between the data and the stop bits. Mode bit 7 selects odd parity when 1 and even parity when 0, so that the total count of ones in the data plus parity bits is odd or even respectively.
- R4: Mode bit 8 set gives two stop bits per character; clear gives one.
- R5: The characters of one packet follow each other with no idle cycle between the end of one stop bit and the next start bit. Each packet consumes exactly its queued count of bytes.
- R6: The start bit of a queued packet follows the end of the previous packet's last stop bit by G*S*`div_i` + 1 + L cycles. G is mode bits [17:10], S is 4 when mode bit 9 is set and 1 otherwise, and L is the lead time in mode bits [3:0].
- R7: When mode bit 5 (automatic drive) is set, `drv_en_o` rises exactly L cycles before a packet's first start bit. It stays high through the last stop bit and is low in the cycle after it.
- R8: When mode bit 4 (manual drive) is set, `drv_en_o` is 1 at all times, including while idle.
- R9: Status bits [25:21] give the number of queued packet lengths not yet started, bit 20 is 1 while the data queue is non-empty, and bit 18 is 1 while the transmitter is active. A length pushed in the same cycle as the transmitter takes one leaves the count unchanged. Status bits [17:0] echo the mode configuration.
- R10: Status bit 19 is a sticky error. It is set by a length push of zero, or by a length push while the length queue is full, and that push is discarded. Reset or the clear command clears it.
- R11: Writing exactly 0x80010000 to the mode word aborts any transmission at once, empties both queues and clears the error, and leaves the configuration unchanged. A push in the same cycle is discarded. Any other mode write loads bits [17:0] as configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | 16 | Clock cycles per bit time (0 treated as 1) |
| mode_wr_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 32 | Mode word write value |
| data_push_i | input | 1 | Push one byte into the data queue |
| data_i | input | 8 | Byte to push |
| len_push_i | input | 1 | Push one packet length into the length queue |
| len_i | input | 8 | Packet length in bytes |
| status_o | output | 32 | Status and configuration word |
| txd_o | output | 1 | Serial output line |
| drv_en_o | output | 1 | External line driver enable |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a length push and the transmitter taking the head length. The bench pushes two lengths in consecutive cycles to an idle transmitter with an empty queue, so the second push lands on the cycle of the first pickup. It then expects a pending count of one and the transmitter busy. The second pair is the clear command and a data push, which the bench drives in one cycle. It then expects the data-present flag low, the error cleared and the configuration echo unchanged. A scoreboard also measures, to the exact cycle, the spacing between characters, the packet gap and the driver lead time.

// File: rtl/pkt_uart_tx_pkg.sv
package pkt_uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GAP
    } tx_state_e;

    // Configuration fields; bit positions are the mode word layout.
    typedef struct packed {
        logic [7:0] gap;       // [17:10] packet gap in bit times
        logic       gap_x4;    // [9]
        logic       stop2;     // [8]
        logic       par_odd;   // [7]
        logic       par_en;    // [6]
        logic       de_auto;   // [5]
        logic       de_manual; // [4]
        logic [3:0] de_lead;   // [3:0] clocks of driver lead
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam logic [31:0] CLEAR_CMD = 32'h8001_0000;

endpackage

// File: rtl/pkt_uart_fifo.sv
module pkt_uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t         ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    assign empty = (ptr_q.lvl == '0);
    assign full  = (ptr_q.lvl == LW'(DEPTH));
    assign level = ptr_q.lvl;
    assign dout  = mem[ptr_q.rd];

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        if (clr) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wr = (ptr_q.wr == AW'(DEPTH - 1)) ? '0 : ptr_q.wr + 1'b1;
            if (do_pop)  ptr_d.rd = (ptr_q.rd == AW'(DEPTH - 1)) ? '0 : ptr_q.rd + 1'b1;
            ptr_d.lvl = ptr_q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wr] <= din;
    end

    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.lvl <= LW'(DEPTH));

endmodule

// File: rtl/pkt_uart_baud.sv
module pkt_uart_baud #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] div,
    output logic          tick
);

    logic [DW:0] cnt_d, cnt_q;
    logic        last;

    always_comb begin
        last  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, div};
        tick  = last && !clr;
        cnt_d = (clr || last) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DW'(1)) |=> !tick);

endmodule

// File: rtl/pkt_uart_engine.sv
module pkt_uart_engine
    import pkt_uart_tx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  mode_t            mode,
    input  logic             tick,
    input  logic             len_empty,
    input  logic [LEN_W-1:0] len_head,
    input  logic [7:0]       byte_head,
    output logic             len_pop,
    output logic             byte_pop,
    output logic             baud_clr,
    output logic             busy,
    output logic             txd,
    output logic             drv_en
);

    typedef struct packed {
        tx_state_e        st;
        logic [3:0]       lead;
        logic [LEN_W-1:0] left;
        logic [7:0]       sh;
        logic             par;
        logic [2:0]       bitn;
        logic             stop_b;
        logic [9:0]       gap;
    } eng_t;

    eng_t       r_d, r_q;
    logic [9:0] gap_total;

    assign gap_total = mode.gap_x4 ? {mode.gap, 2'b00} : {2'b00, mode.gap};

    always_comb begin
        r_d      = r_q;
        len_pop  = 1'b0;
        byte_pop = 1'b0;
        if (abort) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: if (!len_empty) begin
                    len_pop  = 1'b1;
                    r_d.left = len_head;
                    r_d.lead = mode.de_lead;
                    if (mode.de_lead == 4'd0) begin
                        byte_pop = 1'b1;
                        r_d.st   = ST_START;
                    end else begin
                        r_d.st   = ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (r_q.lead == 4'd1) begin
                        byte_pop = 1'b1;
                        r_d.st   = ST_START;
                    end
                    r_d.lead = r_q.lead - 1'b1;
                end
                ST_START: if (tick) begin
                    r_d.st   = ST_DATA;
                    r_d.bitn = '0;
                end
                ST_DATA: if (tick) begin
                    r_d.sh   = {1'b0, r_q.sh[7:1]};
                    r_d.bitn = r_q.bitn + 1'b1;
                    if (r_q.bitn == 3'd7) begin
                        r_d.st     = mode.par_en ? ST_PAR : ST_STOP;
                        r_d.stop_b = 1'b0;
                    end
                end
                ST_PAR: if (tick) begin
                    r_d.st     = ST_STOP;
                    r_d.stop_b = 1'b0;
                end
                ST_STOP: if (tick) begin
                    if (mode.stop2 && !r_q.stop_b) begin
                        r_d.stop_b = 1'b1;
                    end else if (r_q.left > LEN_W'(1)) begin
                        r_d.left = r_q.left - 1'b1;
                        byte_pop = 1'b1;
                        r_d.st   = ST_START;
                    end else begin
                        r_d.gap = gap_total;
                        r_d.st  = (gap_total == '0) ? ST_IDLE : ST_GAP;
                    end
                end
                ST_GAP: if (tick) begin
                    r_d.gap = r_q.gap - 1'b1;
                    if (r_q.gap == 10'd1) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
            if (byte_pop) begin
                r_d.sh  = byte_head;
                r_d.par = (^byte_head) ^ mode.par_odd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = r_q.sh[0];
            ST_PAR:   txd = r_q.par;
            default:  txd = 1'b1;
        endcase
        busy     = (r_q.st != ST_IDLE);
        baud_clr = (r_q.st == ST_IDLE) || (r_q.st == ST_LEAD);
        drv_en   = mode.de_manual ||
                   (mode.de_auto && r_q.st != ST_IDLE && r_q.st != ST_GAP);
    end

    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    a_r7_drive_covers_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.de_auto && !txd) |-> drv_en);
    a_r5_pickup: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !len_empty && !abort) |=> busy);

endmodule

// File: rtl/pkt_uart_tx.sv
module pkt_uart_tx
    import pkt_uart_tx_pkg::*;
#(
    parameter int DATA_DEPTH = 64,
    parameter int LEN_DEPTH  = 16,
    parameter int LEN_W      = 8,
    parameter int DIV_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             mode_wr_i,
    input  logic [31:0]      mode_wdata_i,
    input  logic             data_push_i,
    input  logic [7:0]       data_i,
    input  logic             len_push_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [31:0]      status_o,
    output logic             txd_o,
    output logic             drv_en_o
);

    localparam int DLW = $clog2(DATA_DEPTH + 1);
    localparam int LLW = $clog2(LEN_DEPTH + 1);

    typedef struct packed {
        mode_t mode;
        logic  err;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic             clr, len_ok;
    logic             len_empty, len_full, len_pop;
    logic [LEN_W-1:0] len_head;
    logic [LLW-1:0]   len_lvl;
    logic             dat_empty, dat_full, dat_pop;
    logic [7:0]       dat_head;
    logic [DLW-1:0]   dat_lvl;
    logic             tick, baud_clr, busy;

    assign clr    = mode_wr_i && (mode_wdata_i == CLEAR_CMD);
    assign len_ok = len_push_i && (len_i != '0);

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.err = 1'b0;
        end else begin
            if (mode_wr_i) c_d.mode = mode_t'(mode_wdata_i[MODE_W-1:0]);
            if (len_push_i && (len_i == '0 || len_full)) c_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    pkt_uart_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_data_q (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(data_push_i), .din(data_i), .pop(dat_pop),
        .dout(dat_head), .empty(dat_empty), .full(dat_full), .level(dat_lvl)
    );

    pkt_uart_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_len_q (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(len_ok), .din(len_i), .pop(len_pop),
        .dout(len_head), .empty(len_empty), .full(len_full), .level(len_lvl)
    );

    pkt_uart_baud #(.DW(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .clr(baud_clr), .div(div_i), .tick(tick)
    );

    pkt_uart_engine #(.LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(clr), .mode(c_q.mode), .tick(tick),
        .len_empty(len_empty), .len_head(len_head), .byte_head(dat_head),
        .len_pop(len_pop), .byte_pop(dat_pop), .baud_clr(baud_clr),
        .busy(busy), .txd(txd_o), .drv_en(drv_en_o)
    );

    always_comb begin
        status_o        = '0;
        status_o[17:0]  = c_q.mode;
        status_o[18]    = busy;
        status_o[19]    = c_q.err;
        status_o[20]    = !dat_empty;
        status_o[25:21] = 5'(len_lvl);
    end

    a_r11_clear_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status_o[25:18] == 8'd0 && txd_o));
    a_r10_zero_length_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (len_push_i && len_i == '0 && !clr) |=> status_o[19]);
    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[19] && !clr) |=> status_o[19]);

endmodule

// File: tb/pkt_uart_tx_test.sv
module pkt_uart_tx_test;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_i = 16'(DIV);
    logic        mode_wr_i = 1'b0;
    logic [31:0] mode_wdata_i = '0;
    logic        data_push_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        len_push_i = 1'b0;
    logic [7:0]  len_i = '0;
    logic [31:0] status_o;
    logic        txd_o, drv_en_o;

    pkt_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i),
        .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i),
        .data_push_i(data_push_i), .data_i(data_i),
        .len_push_i(len_push_i), .len_i(len_i),
        .status_o(status_o), .txd_o(txd_o), .drv_en_o(drv_en_o)
    );

    always #5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] b;
        int         lead_exp;  // -1: not checked
        int         gap_exp;   // -1: not checked
        bit         drv_stop;  // expect driver on in stop bit
        bit         drop;      // expect driver off after stop
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 1'b1;
    bit   m_pen = 1'b0, m_odd = 1'b0, m_s2 = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int gap, input bit x4, input bit s2, input bit odd,
                                       input bit pen, input bit aut, input bit man, input int lead);
        return {14'd0, 8'(gap), x4, s2, odd, pen, aut, man, 4'(lead)};
    endfunction

    // All drive tasks: entered just after a negedge, return just after a negedge.
    task automatic wr_mode(input logic [31:0] v);
        mode_wr_i = 1'b1; mode_wdata_i = v;
        if (v != 32'h8001_0000) begin m_pen = v[6]; m_odd = v[7]; m_s2 = v[8]; end
        @(negedge clk);
        mode_wr_i = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        data_push_i = 1'b1; data_i = b;
        @(negedge clk);
        data_push_i = 1'b0;
    endtask

    task automatic push_len(input int n);
        len_push_i = 1'b1; len_i = 8'(n);
        @(negedge clk);
        len_push_i = 1'b0;
    endtask

    function automatic exp_t item(input logic [7:0] b, input int lead, input int gap,
                                  input bit ds, input bit dr);
        exp_t e;
        e.b = b; e.lead_exp = lead; e.gap_exp = gap; e.drv_stop = ds; e.drop = dr;
        return e;
    endfunction

    task automatic wait_idle();
        while (q.size() != 0 || status_o[18]) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard
    int         run;
    bit         drop_pending;
    longint     prev_end;
    longint     s;
    logic [7:0] d;
    logic       pv, sb1, sb2, ds;
    exp_t       e;
    initial begin
        run = 0; drop_pending = 1'b0; prev_end = 0;
        forever begin
            @(negedge clk);
            if (drop_pending) begin
                chk(drv_en_o == 1'b0, "R7 driver released after last stop", drv_en_o, 0);
                drop_pending = 1'b0;
            end
            if (mon_on && txd_o == 1'b0) begin
                s = cyc;
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    d[i] = txd_o;
                end
                pv = 1'b0; sb2 = 1'b1;
                if (m_pen) begin repeat (DIV) @(negedge clk); pv = txd_o; end
                repeat (DIV) @(negedge clk);
                sb1 = txd_o; ds = drv_en_o;
                if (m_s2) begin repeat (DIV) @(negedge clk); sb2 = txd_o; end
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected character", d, 0);
                end else begin
                    e = q.pop_front();
                    chk(d == e.b, "R2 data bits", d, e.b);
                    chk(sb1 == 1'b1, "R2 stop bit", sb1, 1);
                    if (m_s2) chk(sb2 == 1'b1, "R4 second stop bit", sb2, 1);
                    if (m_pen) chk(pv == ((^e.b) ^ m_odd), "R3 parity bit", pv, (^e.b) ^ m_odd);
                    if (e.gap_exp == 0)
                        chk(s - prev_end == 0, "R5 back-to-back", s - prev_end, 0);
                    else if (e.gap_exp > 0)
                        chk(s - prev_end == e.gap_exp, "R6 packet gap", s - prev_end, e.gap_exp);
                    if (e.lead_exp >= 0)
                        chk(run == e.lead_exp, "R7 driver lead", run, e.lead_exp);
                    if (e.drv_stop) chk(ds == 1'b1, "R7 driver on in stop", ds, 1);
                    drop_pending = e.drop;
                end
                prev_end = s + longint'((10 + int'(m_pen) + int'(m_s2)) * DIV);
                repeat (DIV - 1) @(negedge clk);
                run = 0;
            end else begin
                run = drv_en_o ? run + 1 : 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd_o == 1'b1, "R1 line idle", txd_o, 1);
        chk(drv_en_o == 1'b0, "R1 driver off", drv_en_o, 0);
        chk(status_o == 32'd0, "R1 status", status_o, 0);

        // Basic packet, auto drive with lead 3, R2 R5 R7
        wr_mode(mk(2, 0, 0, 0, 0, 1, 0, 3));
        q.push_back(item(8'hA5, 3, -1, 1, 0));
        q.push_back(item(8'h3C, -1, 0, 1, 1));
        push_byte(8'hA5);
        push_byte(8'h3C);
        push_len(2);
        wait_idle();

        // Even parity, two stop bits, two packets; R3 R4 R6 R9 same-cycle push and pop
        wr_mode(mk(5, 0, 1, 0, 1, 1, 0, 2));
        q.push_back(item(8'h81, 2, -1, 1, 1));
        q.push_back(item(8'h7E, 2, 5 * DIV + 1 + 2, 1, 0));
        q.push_back(item(8'h00, -1, 0, 1, 1));
        push_byte(8'h81);
        push_byte(8'h7E);
        push_byte(8'h00);
        push_len(1);
        push_len(2);
        chk(status_o[25:21] == 5'd1, "R9 pending count with simultaneous push and pickup", status_o[25:21], 1);
        chk(status_o[18] == 1'b1, "R9 busy after pickup", status_o[18], 1);
        chk(status_o[20] == 1'b1, "R9 data present", status_o[20], 1);
        wait_idle();

        // Odd parity, scaled gap; R3 R6
        wr_mode(mk(3, 1, 0, 1, 1, 1, 0, 1));
        q.push_back(item(8'hF0, 1, -1, 1, 1));
        q.push_back(item(8'h55, 1, 12 * DIV + 1 + 1, 1, 1));
        push_byte(8'hF0);
        push_byte(8'h55);
        push_len(1);
        push_len(1);
        wait_idle();

        // Manual drive; R8
        wr_mode(mk(0, 0, 0, 0, 0, 0, 1, 0));
        @(negedge clk);
        chk(drv_en_o == 1'b1, "R8 manual drive while idle", drv_en_o, 1);
        q.push_back(item(8'h96, -1, -1, 1, 0));
        push_byte(8'h96);
        push_len(1);
        wait_idle();
        chk(drv_en_o == 1'b1, "R8 manual drive after packet", drv_en_o, 1);

        // Status, error, clear with simultaneous push; R9 R10 R11
        wr_mode(mk(7, 0, 0, 0, 0, 0, 0, 5));
        push_byte(8'h12);
        chk(status_o[20] == 1'b1 && status_o[25:21] == 5'd0 && status_o[18] == 1'b0,
            "R9 data without length", status_o, 32'h0010_0000);
        push_len(0);
        chk(status_o[19] == 1'b1, "R10 zero length error", status_o[19], 1);
        chk(status_o[25:21] == 5'd0, "R10 zero length discarded", status_o[25:21], 0);
        data_push_i = 1'b1; data_i = 8'h34;
        wr_mode(32'h8001_0000);
        data_push_i = 1'b0;
        chk(status_o == mk(7, 0, 0, 0, 0, 0, 0, 5), "R11 clear flushes and keeps config",
            status_o, mk(7, 0, 0, 0, 0, 0, 0, 5));

        // Clear aborts a running packet; R11
        mon_on = 1'b0;
        wr_mode(mk(0, 0, 0, 0, 0, 1, 0, 0));
        push_byte(8'h00);
        push_byte(8'h00);
        push_len(2);
        repeat (10) @(negedge clk);
        chk(txd_o == 1'b0, "R2 character in progress", txd_o, 0);
        wr_mode(32'h8001_0000);
        chk(txd_o == 1'b1 && drv_en_o == 1'b0 && status_o[25:18] == 8'd0,
            "R11 abort", {txd_o, drv_en_o, status_o[25:18]}, 10'h200);
        begin
            bit stayed = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (txd_o !== 1'b1 || status_o[18]) stayed = 1'b0;
            end
            chk(stayed, "R11 no transmission after abort", stayed, 1);
        end
        mon_on = 1'b1;

        // Full length queue; R10
        wr_mode(mk(255, 1, 0, 0, 0, 1, 0, 0));
        q.push_back(item(8'hC3, 0, -1, 1, 1));
        push_byte(8'hC3);
        push_len(1);
        for (int i = 0; i < 16; i++) push_len(1);
        chk(status_o[25:21] == 5'd16 && status_o[19] == 1'b0, "R9 queue filled",
            {status_o[25:21], status_o[19]}, {5'd16, 1'b0});
        push_len(1);
        chk(status_o[19] == 1'b1 && status_o[25:21] == 5'd16, "R10 push to full queue",
            {status_o[25:21], status_o[19]}, {5'd16, 1'b1});
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        wr_mode(32'h8001_0000);
        chk(status_o[25:18] == 8'd0, "R11 clear during gap", status_o[25:18], 0);

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R5 all expected characters seen", q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule